// File: doc/BRIEF.md
# Clear-to-Send Gated Serial Byte Transmitter

This block takes bytes from a small local queue and shifts them out one bit per serial tick on an unframed serial line. It does not start a byte until the far end grants clear-to-send. The queue accepts bytes through a write port with a full flag. Its usable depth is either the full configured size or a single byte. The single-byte setting gives the lowest latency between a write and the start of that byte on the line.

Three mode inputs are captured while the transmitter is disabled and are held for as long as it stays enabled:

- **CTS sampling.** CTS can be used directly, for a source whose CTS changes in step with the serial clock. It can also go through a synchronizer chain that adds a fixed number of serial ticks of delay.
- **Queue depth.** Either the full configured size or a single byte.
- **Receiver lock.** The start of transmission can be locked to a companion receiver. No byte then starts until the receiver reports that data has begun arriving. After that, a byte may start only on a whole multiple of eight bit periods from that event.

The serial clock is supplied as a one-cycle enable, `bit_en`, in the block's clock domain. Every register updates on `clk`, and the line and start logic advance only on cycles where `bit_en` is high.

Top module: `txg_serial_tx`

## Requirements
- R1: After reset, `txd` is 1, `fifo_full` is 0 and `overflow` is 0.
- R2: In full-depth mode (`cfg_short_fifo` = 0 at enable time), `fifo_full` rises once 32 bytes are held. A write while `fifo_full` is 1 is discarded and sets `overflow`. `overflow` stays 1 until reset.
- R3: In single-byte mode (`cfg_short_fifo` = 1), `fifo_full` is 1 whenever one byte is held. A second write is discarded, so only one byte is sent.
- R4: Each byte is sent least significant bit first, as 8 bit periods. `txd` changes only in the cycle after a cycle with `bit_en` = 1, or when the transmitter is disabled.
- R5: In direct CTS mode (`cfg_cts_direct` = 1), a byte starts at the first `bit_en` where `cts_n` is 0 and the queue is not empty. Bit 0 appears on `txd` one clock later.
- R6: In synchronized CTS mode (`cfg_cts_direct` = 0), `cts_n` is sampled on `bit_en` cycles. A byte can start no earlier than the third `bit_en` after the first one that samples `cts_n` = 0.
- R7: If CTS is withdrawn in the middle of a byte, that byte is still sent in full. No further byte starts until CTS is granted again, and meanwhile `txd` is 1.
- R8: With receiver lock enabled (`cfg_rx_lock` = 1), no byte starts before a `rx_sync` pulse. The first eligible start is the 8th `bit_en` after the pulse, and later starts fall only on multiples of 8 `bit_en` cycles from the pulse.
- R9: Changes on the three `cfg_*` inputs while `tx_enable` is 1 have no effect. They take effect from the next enable.
- R10: Bytes that are queued when the previous byte ends follow with no idle bit between them. When the queue is empty, `txd` is 1.
- R11: Deasserting `tx_enable` aborts any byte in progress, and `txd` is 1 from the next clock. Queued bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable; mode inputs are captured while low |
| cfg_cts_direct | input | 1 | 1: use CTS directly; 0: use CTS through the synchronizer chain |
| cfg_short_fifo | input | 1 | 1: queue limited to one byte |
| cfg_rx_lock | input | 1 | 1: lock byte starts to the receiver sync event |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds its selected depth |
| overflow | output | 1 | Sticky: a write was dropped because the queue was full |
| bit_en | input | 1 | Serial clock tick, one cycle wide |
| cts_n | input | 1 | Clear-to-send, active low |
| rx_sync | input | 1 | Pulse: the companion receiver began receiving data |
| txd | output | 1 | Serial data out, idles at 1 |

## Verification
The assertions check, on every cycle:
- `txd` changes only after a serial tick;
- a started byte is never dropped while the transmitter is enabled;
- disabling forces the line idle;
- captured modes stay fixed while enabled;
- a full queue ignores writes and the overflow flag stays set;
- no start happens in lock mode before a receiver sync.

Other behaviour depends on exact sequences, and only the bench's scenarios can show it:
- bit order;
- the three-tick delay of synchronized CTS;
- the 8-tick alignment after `rx_sync`;
- completion of a byte after CTS is withdrawn;
- back-to-back bytes with no gap;
- the depth switch taking effect only at the next enable.

// File: rtl/txg_pkg.sv
package txg_pkg;

   typedef struct packed {
      logic cts_direct;
      logic short_fifo;
      logic rx_lock;
   } txg_mode_t;

endpackage

// File: rtl/txg_fifo.sv
module txg_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              short_mode,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic              overflow
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("txg_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] store [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic [CW-1:0]     count;
   logic [CW-1:0]     limit;
   logic              push, pop;

   assign limit   = short_mode ? CW'(1) : CW'(DEPTH);
   assign full    = count >= limit;
   assign empty   = count == '0;
   assign push    = wr_valid && !full;
   assign pop     = rd_en && !empty;
   assign rd_data = store[rp];

   always_ff @(posedge clk) begin
      if (push) store[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
         if (wr_valid && full) overflow <= 1'b1;
      end
   end

   // R2: a write into a full queue leaves the fill level untouched
   assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && full && !pop) |=> (count == $past(count)));

   // R2: the overflow flag never clears once set
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

endmodule

// File: rtl/txg_start_gate.sv
module txg_start_gate
   import txg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_BITS  = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enable,
   input  logic      bit_en,
   input  logic      cts_n,
   input  logic      rx_sync,
   input  txg_mode_t mode,
   output logic      start_ok
);
   localparam int PW = $clog2(FRAME_BITS);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("txg_start_gate: SYNC_STAGES must be at least 2");
      end
      if (FRAME_BITS < 2 || (1 << PW) != FRAME_BITS) begin : g_bad_frame
         $error("txg_start_gate: FRAME_BITS must be a power of two");
      end
   endgenerate

   // Synchronizer stages followed by one qualification stage
   logic [SYNC_STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[0] <= 1'b0;
      else if (bit_en) chain[0] <= !cts_n;
   end

   for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= 1'b0;
         else if (bit_en) chain[s] <= chain[s-1];
      end
   end

   logic          cts_ok;
   logic          seen;
   logic [PW-1:0] phase;
   logic          rx_ok;

   assign cts_ok = mode.cts_direct ? !cts_n : chain[SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen  <= 1'b0;
         phase <= '0;
      end else if (!enable) begin
         seen  <= 1'b0;
         phase <= '0;
      end else if (rx_sync && !seen) begin
         seen  <= 1'b1;
         phase <= '0;
      end else if (seen && bit_en) begin
         phase <= phase + 1'b1;
      end
   end

   assign rx_ok    = !mode.rx_lock || (seen && phase == PW'(FRAME_BITS - 1));
   assign start_ok = cts_ok && rx_ok;

   // R8: in lock mode nothing may start before the receiver has synced
   assert_lock_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.rx_lock && !seen) |-> !start_ok);

endmodule

// File: rtl/txg_shifter.sv
module txg_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              bit_en,
   input  logic              go_ok,
   input  logic [DATA_W-1:0] din,
   output logic              load,
   output logic              txd
);
   localparam int CW = $clog2(DATA_W);

   logic [DATA_W-1:0] sh;
   logic [CW-1:0]     left;
   logic              busy;
   logic              slot_free;

   assign slot_free = !busy || left == '0;
   assign load      = enable && bit_en && slot_free && go_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         left <= '0;
         busy <= 1'b0;
         txd  <= 1'b1;
      end else if (!enable) begin
         busy <= 1'b0;
         left <= '0;
         txd  <= 1'b1;
      end else if (bit_en) begin
         if (load) begin
            txd  <= din[0];
            sh   <= din >> 1;
            left <= CW'(DATA_W - 1);
            busy <= 1'b1;
         end else if (busy && left != '0) begin
            txd  <= sh[0];
            sh   <= sh >> 1;
            left <= left - 1'b1;
         end else begin
            busy <= 1'b0;
            txd  <= 1'b1;
         end
      end
   end

   // R4: the line only moves on a serial tick
   assert_tick_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && enable) |=> $stable(txd));

   // R7: a byte under way is carried to its end while enabled
   assert_byte_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && left != '0 && enable) |=> busy);

   // R11: disabling idles the line on the next clock
   assert_disable_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (txd && !busy));

endmodule

// File: rtl/txg_serial_tx.sv
module txg_serial_tx
   import txg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int FIFO_DEPTH  = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_BITS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_enable,
   input  logic              cfg_cts_direct,
   input  logic              cfg_short_fifo,
   input  logic              cfg_rx_lock,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              fifo_full,
   output logic              overflow,
   input  logic              bit_en,
   input  logic              cts_n,
   input  logic              rx_sync,
   output logic              txd
);
   txg_mode_t         mode_q;
   logic              start_ok;
   logic              empty;
   logic              load;
   logic [DATA_W-1:0] head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (!tx_enable) begin
         mode_q.cts_direct <= cfg_cts_direct;
         mode_q.short_fifo <= cfg_short_fifo;
         mode_q.rx_lock    <= cfg_rx_lock;
      end
   end

   txg_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .short_mode (mode_q.short_fifo),
      .wr_valid   (wr_valid),
      .wr_data    (wr_data),
      .rd_en      (load),
      .rd_data    (head),
      .empty      (empty),
      .full       (fifo_full),
      .overflow   (overflow)
   );

   txg_start_gate #(.SYNC_STAGES(SYNC_STAGES), .FRAME_BITS(FRAME_BITS)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (tx_enable),
      .bit_en   (bit_en),
      .cts_n    (cts_n),
      .rx_sync  (rx_sync),
      .mode     (mode_q),
      .start_ok (start_ok)
   );

   txg_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (tx_enable),
      .bit_en (bit_en),
      .go_ok  (start_ok && !empty),
      .din    (head),
      .load   (load),
      .txd    (txd)
   );

   // R9: captured modes hold while the transmitter runs
   assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_enable |=> $stable(mode_q));

   // R5: nothing leaves an empty queue
   assert_no_empty_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !load);

endmodule

// File: tb/txg_serial_tx_bench.sv
module txg_serial_tx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int DEPTH      = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_enable = 1'b0;
   logic cfg_cts_direct = 1'b1, cfg_short_fifo = 1'b0, cfg_rx_lock = 1'b0;
   logic wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic fifo_full, overflow, txd;
   logic bit_en = 1'b0;
   logic cts_n = 1'b1;
   logic rx_sync = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = !clk;

   txg_serial_tx u_txg_serial_tx (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable),
      .cfg_cts_direct(cfg_cts_direct), .cfg_short_fifo(cfg_short_fifo),
      .cfg_rx_lock(cfg_rx_lock), .wr_valid(wr_valid), .wr_data(wr_data),
      .fifo_full(fifo_full), .overflow(overflow), .bit_en(bit_en),
      .cts_n(cts_n), .rx_sync(rx_sync), .txd(txd)
   );

   // Serial tick: one cycle in TICK_DIV
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv   = (tdiv + 1) % TICK_DIV;
      bit_en = (tdiv == 0);
   end

   // Behavioural reference
   logic [7:0] q[$];
   bit m_dir, m_short, m_lock;
   bit r_busy, r_txd = 1'b1, r_ovf;
   int r_left, r_bits;
   bit [2:0] r_ch;
   bit r_seen;
   int r_phase;

   always @(posedge clk) begin : model
      int lim;
      bit full_old, empty_old, ctsok, rxok, ld;
      logic [7:0] d;
      if (!rst_n) begin
         q.delete();
         m_dir = 0; m_short = 0; m_lock = 0;
         r_busy = 0; r_txd = 1; r_ovf = 0; r_left = 0; r_bits = 0;
         r_ch = 0; r_seen = 0; r_phase = 0;
      end else begin
         lim       = m_short ? 1 : DEPTH;
         full_old  = q.size() >= lim;
         empty_old = q.size() == 0;
         ctsok     = m_dir ? !cts_n : r_ch[2];
         rxok      = !m_lock || (r_seen && r_phase == 7);
         ld = tx_enable && bit_en && (!r_busy || r_left == 0) && ctsok && rxok && !empty_old;
         if (!tx_enable) begin
            r_busy = 0; r_left = 0; r_txd = 1;
         end else if (bit_en) begin
            if (ld) begin
               d = q.pop_front();
               r_txd = d[0]; r_bits = d >> 1; r_left = 7; r_busy = 1;
            end else if (r_busy && r_left != 0) begin
               r_txd = r_bits[0]; r_bits = r_bits >> 1; r_left--;
            end else begin
               r_busy = 0; r_txd = 1;
            end
         end
         if (wr_valid && !full_old) q.push_back(wr_data);
         else if (wr_valid) r_ovf = 1;
         if (bit_en) r_ch = {r_ch[1:0], !cts_n};
         if (!tx_enable) begin
            r_seen = 0; r_phase = 0;
         end else if (rx_sync && !r_seen) begin
            r_seen = 1; r_phase = 0;
         end else if (r_seen && bit_en) begin
            r_phase = (r_phase + 1) % 8;
         end
         if (!tx_enable) begin
            m_dir = cfg_cts_direct; m_short = cfg_short_fifo; m_lock = cfg_rx_lock;
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check(tag, "txd", txd, r_txd);
         check(tag, "fifo_full", fifo_full, (q.size() >= (m_short ? 1 : DEPTH)));
         check(tag, "overflow", overflow, r_ovf);
      end
   end

   task automatic clks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = b;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      while (cycles < 150000) @(negedge clk);
      fails++; checks++;
      $display("FAIL watchdog: actual hang expected completion");
      finish_run();
   end

   initial begin
      clks(3);
      check("R1", "reset txd", txd, 1);
      check("R1", "reset full", fifo_full, 0);
      check("R1", "reset overflow", overflow, 0);
      rst_n = 1'b1;
      clks(2);

      // R2: fill the deep queue while disabled
      tag = "R2";
      for (int i = 0; i < DEPTH; i++) put(8'(i * 7 + 3));
      clks(1);
      check("R2", "full at depth", fifo_full, 1);
      check("R2", "no overflow yet", overflow, 0);
      put(8'hEE);
      clks(1);
      check("R2", "overflow set", overflow, 1);

      // R5, R4, R10: direct CTS, back-to-back drain
      tag = "R5_R4_R10";
      cfg_cts_direct = 1'b1; cts_n = 1'b0;
      clks(1); tx_enable = 1'b1;
      clks(DEPTH * 8 * TICK_DIV + 40);
      check("R10", "idle after drain", txd, 1);

      // R7: withdraw CTS mid-byte
      tag = "R7";
      put(8'hA5); put(8'h3C); put(8'h81);
      clks(3 * TICK_DIV);
      cts_n = 1'b1;
      clks(30 * TICK_DIV);
      check("R7", "idle while CTS withdrawn", txd, 1);
      cts_n = 1'b0;
      clks(30 * TICK_DIV);

      // R6: synchronized CTS
      tag = "R6";
      tx_enable = 1'b0; cts_n = 1'b1; cfg_cts_direct = 1'b0;
      clks(2); tx_enable = 1'b1;
      put(8'h5A); put(8'hC3);
      clks(10 * TICK_DIV);
      cts_n = 1'b0;
      clks(24 * TICK_DIV);

      // R9: depth change while enabled is ignored
      tag = "R9";
      cts_n = 1'b1; cfg_short_fifo = 1'b1;
      clks(2);
      put(8'h11);
      clks(1);
      check("R9", "short depth ignored while enabled", fifo_full, 0);
      put(8'h22);
      tx_enable = 1'b0;
      clks(2);
      check("R9", "short depth applied after re-capture", fifo_full, 1);
      tx_enable = 1'b1; cfg_cts_direct = 1'b1;
      tx_enable = 1'b0; clks(2); tx_enable = 1'b1;
      cts_n = 1'b0;
      clks(20 * TICK_DIV);

      // R3: single-byte queue
      tag = "R3";
      cts_n = 1'b1;
      put(8'h96);
      clks(1);
      check("R3", "full after one byte", fifo_full, 1);
      put(8'h69);
      cts_n = 1'b0;
      clks(20 * TICK_DIV);
      check("R3", "second byte dropped, line idle", txd, 1);

      // R8: receiver lock
      tag = "R8";
      tx_enable = 1'b0; cfg_rx_lock = 1'b1; cfg_short_fifo = 1'b0;
      clks(2); tx_enable = 1'b1;
      put(8'hF0); put(8'h0F);
      clks(20 * TICK_DIV);
      check("R8", "no start before sync", txd, 1);
      @(negedge clk); rx_sync = 1'b1;
      @(negedge clk); rx_sync = 1'b0;
      clks(30 * TICK_DIV);
      put(8'h55);
      clks(21 * TICK_DIV + 3);
      put(8'hAA);
      clks(30 * TICK_DIV);

      // R11: disable aborts a byte
      tag = "R11";
      tx_enable = 1'b0; cfg_rx_lock = 1'b0;
      clks(2); tx_enable = 1'b1;
      put(8'h00); put(8'h00);
      clks(4 * TICK_DIV);
      tx_enable = 1'b0;
      clks(1);
      check("R11", "idle after disable", txd, 1);
      clks(4);
      tx_enable = 1'b1;
      clks(20 * TICK_DIV);

      finish_run();
   end
endmodule